// File: doc/BRIEF.md
# PCIe Host Bridge Request Translator

This block sits between a processor-side memory-mapped request port and a downstream PCIe request/completion port. Every processor access is sorted by address. An access inside the configuration window becomes a configuration read or write. Its offset is split into bus, device, function and dword register fields. An access inside the outbound window goes downstream as a memory read or write, but only when it lands in one of the programmed base/limit windows. These windows cover BARs and the prefetchable and non-prefetchable ranges. Addresses pass through untranslated.

The block also shapes the answer returned to the processor. On the root bus, a configuration read to a function marked absent in the presence map never leaves the block and returns all ones. A configuration read whose completion reports Unsupported Request also returns all ones. An outbound access that no enabled window claims, or any address outside both regions, is answered with an error and nothing goes downstream. Only one request is in flight at a time. The processor-side ready stays low until the completion comes back.

Top module: `hbx_bridge`

## Requirements
- R1: A read inside the configuration window (base 0x3000_0000, 256 MiB) issues exactly one request of kind 0 (config read), and a write issues kind 1 (config write) carrying the write data. The request's bus, device, function and register fields are offset bits [27:20], [19:15], [14:12] and [11:2].
- R2: An access inside the outbound region (base 0x4000_0000, 256 MiB) that falls in an enabled window (base <= address <= limit, both inclusive) issues one request of kind 2 (memory read) or 3 (memory write), with the processor address unchanged and the write data carried.
- R3: An outbound-region access that no enabled window covers completes with the error flag set, read data zero and no downstream request. Disabled windows claim nothing.
- R4: An address outside both regions completes with the error flag set and no downstream request.
- R5: A configuration read on the root bus (bus 0) to a function whose presence bit is clear returns 0xFFFF_FFFF with no error and no downstream request. The presence bit index is device*8 + function.
- R6: A configuration read whose completion status is 1 (Unsupported Request) returns 0xFFFF_FFFF with no error. Status 0 means success and status 2 means completer abort.
- R7: A configuration write on the root bus to an absent function completes with no error and no downstream request, and its data is dropped.
- R8: Configuration accesses to any bus other than bus 0 are forwarded regardless of the presence map.
- R9: At most one request is outstanding. Each request is valid for a single cycle. The processor-side ready stays low until the completion arrives, and rises exactly one cycle after the completion cycle.
- R10: A successful read returns the completion data with no error. A memory read or any write with a status other than 0 returns the error flag. A configuration read with a status other than 0 or 1 also returns the error flag.
- R11: During and just after reset, ready and the downstream request valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Processor request valid, held until ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Processor byte address |
| h_wdata | input | DW | Processor write data |
| h_ready | output | 1 | One-cycle response strobe |
| h_rdata | output | DW | Response read data |
| h_err | output | 1 | Response error flag |
| win_base | input | NWIN*AW | Window base addresses, window i at bits [i*AW +: AW] |
| win_limit | input | NWIN*AW | Inclusive window limits, same packing |
| win_en | input | NWIN | Window enables |
| fn_present | input | 256 | Root-bus function presence map, index device*8+function |
| d_req_valid | output | 1 | Downstream request strobe |
| d_req_kind | output | 2 | 0 cfg read, 1 cfg write, 2 mem read, 3 mem write |
| d_req_addr | output | AW | Memory request address |
| d_req_bus | output | 8 | Configuration bus number |
| d_req_dev | output | 5 | Configuration device number |
| d_req_fn | output | 3 | Configuration function number |
| d_req_reg | output | 10 | Configuration dword register index |
| d_req_wdata | output | DW | Write data |
| d_cpl_valid | input | 1 | Completion strobe |
| d_cpl_status | input | 2 | 0 success, 1 Unsupported Request, 2 completer abort |
| d_cpl_data | input | DW | Completion read data |

## Verification
The hardest case to reach is a slow completion. The block must hold a request open and keep ready low for many cycles. It must not re-issue the request or answer early. The bench's completion model answers after a programmable number of cycles. A directed test stretches this to twenty cycles and checks that exactly one request appears and that ready rises exactly one cycle after the completion. The window edges are reached by placing accesses on an inclusive base, on a limit and one step past a limit. The all-ones cases are reached by a mix of absent functions on the root bus and Unsupported Request completions from both root and non-root buses.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;
   localparam int REG_W = 10;
   localparam int CFG_SPAN_LOG2 = BUS_W + DEV_W + FN_W + REG_W + 2;

   typedef enum logic [1:0] {
      K_CFG_RD = 2'd0,
      K_CFG_WR = 2'd1,
      K_MEM_RD = 2'd2,
      K_MEM_WR = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      C_SC = 2'd0,
      C_UR = 2'd1,
      C_CA = 2'd2
   } cpl_sts_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_RESP  = 2'd3
   } seq_st_e;
endpackage

// File: rtl/hbx_addr_decode.sv
module hbx_addr_decode
   import hbx_pkg::*;
#(
   parameter int          AW        = 32,
   parameter logic [63:0] ECAM_BASE = 64'h3000_0000,
   parameter logic [63:0] OUT_BASE  = 64'h4000_0000,
   parameter int          OUT_LOG2  = 28,
   parameter int          ROOT_BUS  = 0
) (
   input  logic [AW-1:0]    addr,
   output logic             in_cfg,
   output logic             in_out,
   output logic             on_root,
   output logic [BUS_W-1:0] bus,
   output logic [DEV_W-1:0] dev,
   output logic [FN_W-1:0]  fn,
   output logic [REG_W-1:0] rg
);
   localparam int FN_LO  = REG_W + 2;
   localparam int DEV_LO = FN_LO + FN_W;
   localparam int BUS_LO = DEV_LO + DEV_W;

   if (AW > 64 || AW <= CFG_SPAN_LOG2) begin : g_bad_aw
      $error("hbx_addr_decode: AW out of range");
   end
   if (ECAM_BASE[CFG_SPAN_LOG2-1:0] != '0) begin : g_bad_cfg_align
      $error("hbx_addr_decode: configuration window not aligned to its span");
   end
   if (OUT_LOG2 < 2 || OUT_LOG2 >= AW) begin : g_bad_out
      $error("hbx_addr_decode: outbound region size out of range");
   end

   assign in_cfg  = (addr[AW-1:CFG_SPAN_LOG2] == ECAM_BASE[AW-1:CFG_SPAN_LOG2]);
   assign in_out  = (addr[AW-1:OUT_LOG2] == OUT_BASE[AW-1:OUT_LOG2]);
   assign bus     = addr[BUS_LO +: BUS_W];
   assign dev     = addr[DEV_LO +: DEV_W];
   assign fn      = addr[FN_LO +: FN_W];
   assign rg      = addr[2 +: REG_W];
   assign on_root = (bus == BUS_W'(ROOT_BUS));

   logic unused_lo;
   assign unused_lo = ^addr[1:0];
endmodule

// File: rtl/hbx_win_match.sv
module hbx_win_match #(
   parameter int AW   = 32,
   parameter int NWIN = 4
) (
   input  logic [AW-1:0]      addr,
   input  logic [NWIN*AW-1:0] base,
   input  logic [NWIN*AW-1:0] limit,
   input  logic [NWIN-1:0]    en,
   output logic               hit
);
   if (NWIN < 1) begin : g_bad_nwin
      $error("hbx_win_match: NWIN must be at least 1");
   end

   logic [NWIN-1:0] hit_vec;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      assign hit_vec[i] = en[i]
                        && (addr >= base[i*AW +: AW])
                        && (addr <= limit[i*AW +: AW]);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/hbx_bridge.sv
module hbx_bridge
   import hbx_pkg::*;
#(
   parameter int          AW              = 32,
   parameter int          DW              = 32,
   parameter int          NWIN            = 4,
   parameter logic [63:0] ECAM_BASE       = 64'h3000_0000,
   parameter logic [63:0] OUT_BASE        = 64'h4000_0000,
   parameter int          OUT_LOG2        = 28,
   parameter int          ROOT_BUS        = 0,
   parameter bit          PRESENCE_FILTER = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   h_valid,
   input  logic                   h_write,
   input  logic [AW-1:0]          h_addr,
   input  logic [DW-1:0]          h_wdata,
   output logic                   h_ready,
   output logic [DW-1:0]          h_rdata,
   output logic                   h_err,
   input  logic [NWIN*AW-1:0]     win_base,
   input  logic [NWIN*AW-1:0]     win_limit,
   input  logic [NWIN-1:0]        win_en,
   input  logic [(1<<(DEV_W+FN_W))-1:0] fn_present,
   output logic                   d_req_valid,
   output logic [1:0]             d_req_kind,
   output logic [AW-1:0]          d_req_addr,
   output logic [BUS_W-1:0]       d_req_bus,
   output logic [DEV_W-1:0]       d_req_dev,
   output logic [FN_W-1:0]        d_req_fn,
   output logic [REG_W-1:0]       d_req_reg,
   output logic [DW-1:0]          d_req_wdata,
   input  logic                   d_cpl_valid,
   input  logic [1:0]             d_cpl_status,
   input  logic [DW-1:0]          d_cpl_data
);
   localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

   if (DW < 8) begin : g_bad_dw
      $error("hbx_bridge: DW too small");
   end

   // ---------------- decode ----------------
   logic             dc_cfg, dc_out, dc_root, win_hit, fn_missing;
   logic [BUS_W-1:0] dc_bus;
   logic [DEV_W-1:0] dc_dev;
   logic [FN_W-1:0]  dc_fn;
   logic [REG_W-1:0] dc_reg;

   hbx_addr_decode #(
      .AW(AW), .ECAM_BASE(ECAM_BASE), .OUT_BASE(OUT_BASE),
      .OUT_LOG2(OUT_LOG2), .ROOT_BUS(ROOT_BUS)
   ) u_decode (
      .addr(h_addr), .in_cfg(dc_cfg), .in_out(dc_out), .on_root(dc_root),
      .bus(dc_bus), .dev(dc_dev), .fn(dc_fn), .rg(dc_reg)
   );

   hbx_win_match #(.AW(AW), .NWIN(NWIN)) u_win (
      .addr(h_addr), .base(win_base), .limit(win_limit), .en(win_en), .hit(win_hit)
   );

   if (PRESENCE_FILTER) begin : g_presence
      assign fn_missing = dc_root && !fn_present[{dc_dev, dc_fn}];
   end else begin : g_no_presence
      logic unused_pres;
      assign unused_pres = ^fn_present;
      assign fn_missing  = 1'b0;
   end

   // ---------------- sequencer ----------------
   seq_st_e          state;
   req_kind_e        r_kind;
   logic [AW-1:0]    r_addr;
   logic [DW-1:0]    r_wdata, r_rdata;
   logic             r_err;
   logic [BUS_W-1:0] r_bus;
   logic [DEV_W-1:0] r_dev;
   logic [FN_W-1:0]  r_fn;
   logic [REG_W-1:0] r_reg;
   logic             take;

   assign take = (state == S_IDLE) && h_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         r_kind  <= K_CFG_RD;
         r_addr  <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
         r_err   <= 1'b0;
         r_bus   <= '0;
         r_dev   <= '0;
         r_fn    <= '0;
         r_reg   <= '0;
      end else begin
         case (state)
            S_IDLE: if (h_valid) begin
               r_addr  <= h_addr;
               r_wdata <= h_wdata;
               r_bus   <= dc_bus;
               r_dev   <= dc_dev;
               r_fn    <= dc_fn;
               r_reg   <= dc_reg;
               r_rdata <= '0;
               r_err   <= 1'b0;
               if (dc_cfg) begin
                  r_kind <= h_write ? K_CFG_WR : K_CFG_RD;
                  if (fn_missing) begin
                     r_rdata <= h_write ? '0 : ALL_ONES;
                     state   <= S_RESP;
                  end else begin
                     state   <= S_ISSUE;
                  end
               end else if (dc_out && win_hit) begin
                  r_kind <= h_write ? K_MEM_WR : K_MEM_RD;
                  state  <= S_ISSUE;
               end else begin
                  r_err  <= 1'b1;
                  state  <= S_RESP;
               end
            end
            S_ISSUE: state <= S_WAIT;
            S_WAIT: if (d_cpl_valid) begin
               state <= S_RESP;
               case (r_kind)
                  K_CFG_RD: begin
                     if (d_cpl_status == C_SC)      r_rdata <= d_cpl_data;
                     else if (d_cpl_status == C_UR) r_rdata <= ALL_ONES;
                     else                           r_err   <= 1'b1;
                  end
                  K_MEM_RD: begin
                     if (d_cpl_status == C_SC) r_rdata <= d_cpl_data;
                     else                      r_err   <= 1'b1;
                  end
                  default: r_err <= (d_cpl_status != C_SC);
               endcase
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign h_ready     = (state == S_RESP);
   assign h_rdata     = r_rdata;
   assign h_err       = r_err;
   assign d_req_valid = (state == S_ISSUE);
   assign d_req_kind  = r_kind;
   assign d_req_addr  = r_addr;
   assign d_req_bus   = r_bus;
   assign d_req_dev   = r_dev;
   assign d_req_fn    = r_fn;
   assign d_req_reg   = r_reg;
   assign d_req_wdata = r_wdata;

   // ---------------- assertions ----------------
   assert_missing_rd_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (PRESENCE_FILTER && take && dc_cfg && dc_root && !fn_present[{dc_dev, dc_fn}] && !h_write)
      |=> (h_ready && !h_err && h_rdata == ALL_ONES && !d_req_valid));

   assert_unclaimed_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !dc_cfg && dc_out && !win_hit) |=> (h_ready && h_err && !d_req_valid));

   assert_outside_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !dc_cfg && !dc_out) |=> (h_ready && h_err));

   assert_ur_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_WAIT) && d_cpl_valid && r_kind == K_CFG_RD && d_cpl_status == C_UR)
      |=> (h_ready && !h_err && h_rdata == ALL_ONES));

   assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      d_req_valid |=> !d_req_valid);

   assert_ready_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_WAIT) && !d_cpl_valid) |=> !h_ready);

   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_ready && d_req_valid));
endmodule

// File: tb/hbx_bridge_tb.sv
module hbx_bridge_tb;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NWIN = 4;
   localparam int NV = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            h_valid = 0, h_write = 0;
   logic [AW-1:0]   h_addr = '0;
   logic [DW-1:0]   h_wdata = '0;
   logic            h_ready, h_err;
   logic [DW-1:0]   h_rdata;
   logic [NWIN*AW-1:0] win_base, win_limit;
   logic [NWIN-1:0] win_en;
   logic [255:0]    fn_present;
   logic            d_req_valid;
   logic [1:0]      d_req_kind;
   logic [AW-1:0]   d_req_addr;
   logic [7:0]      d_req_bus;
   logic [4:0]      d_req_dev;
   logic [2:0]      d_req_fn;
   logic [9:0]      d_req_reg;
   logic [DW-1:0]   d_req_wdata;
   logic            d_cpl_valid = 0;
   logic [1:0]      d_cpl_status = 0;
   logic [DW-1:0]   d_cpl_data = '0;

   hbx_bridge #(.AW(AW), .DW(DW), .NWIN(NWIN)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_ready(h_ready), .h_rdata(h_rdata), .h_err(h_err),
      .win_base(win_base), .win_limit(win_limit), .win_en(win_en),
      .fn_present(fn_present),
      .d_req_valid(d_req_valid), .d_req_kind(d_req_kind), .d_req_addr(d_req_addr),
      .d_req_bus(d_req_bus), .d_req_dev(d_req_dev), .d_req_fn(d_req_fn),
      .d_req_reg(d_req_reg), .d_req_wdata(d_req_wdata),
      .d_cpl_valid(d_cpl_valid), .d_cpl_status(d_cpl_status), .d_cpl_data(d_cpl_data)
   );

   // windows: 0 and 1 and 3 enabled, 2 disabled
   assign win_base  = {32'h4F00_0000, 32'h4800_0000, 32'h4100_0000, 32'h4000_0000};
   assign win_limit = {32'h4FFF_FFFF, 32'h48FF_FFFF, 32'h41FF_FFFF, 32'h4000_FFFF};
   assign win_en    = 4'b1011;
   // root bus presence: dev0/fn0 (bit 0), dev1/fn0 (bit 8), dev3/fn2 (bit 26)
   assign fn_present = (256'd1 << 0) | (256'd1 << 8) | (256'd1 << 26);

   int checks = 0;
   int fails = 0;
   bit done = 0;

   task automatic check(input bit ok, input int tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // vector table: write, addr, wdata, cpl status, cpl data, expect request, kind, err, rdata, tag
   localparam logic        V_WR   [NV] = '{0,1,0,0,1,0,0,0,0,1,0,0,0,0,1,0};
   localparam logic [31:0] V_ADDR [NV] = '{
      32'h3000_0000, // R1 cfg read dev0 fn0
      32'h3000_8010, // R1 cfg write dev1 fn0 reg4
      32'h3001_AFFC, // R6 dev3 fn2 reg 0x3FF, UR
      32'h3001_0000, // R5 absent dev2
      32'h3001_0000, // R7 write absent dev2
      32'h3051_0000, // R8 bus5 dev2 forwarded
      32'h3FFF_FFFC, // R6 bus 0xFF dev31 fn7 UR
      32'h3000_0000, // R10 cfg read completer abort
      32'h4000_0000, // R2 window 0 base edge
      32'h4000_FFFC, // R2 window 0 top dword
      32'h4001_0000, // R3 just past window 0
      32'h4800_0000, // R3 disabled window
      32'h4F00_0010, // R10 mem read UR
      32'h2FFF_FFFC, // R4 below config window
      32'h5000_0000, // R4 above outbound region
      32'h41FF_FFFC  // R2 window 1 top dword
   };
   localparam logic [31:0] V_WD   [NV] = '{0,32'hCAFE_0001,0,0,32'h1111_2222,0,0,0,0,32'hDEAD_BEEF,0,0,0,0,32'h7,0};
   localparam logic [1:0]  V_STS  [NV] = '{0,0,1,0,0,0,1,2,0,0,0,0,1,0,0,0};
   localparam logic [31:0] V_CD   [NV] = '{32'h1234_ABCD,0,32'h5,0,0,32'h55,32'h9,32'h3,32'h777,0,0,0,32'h8,0,0,32'hA5A5};
   localparam logic        V_REQ  [NV] = '{1,1,1,0,0,1,1,1,1,1,0,0,1,0,0,1};
   localparam logic [1:0]  V_KIND [NV] = '{0,1,0,0,1,0,0,0,2,3,2,2,2,2,3,2};
   localparam logic        V_ERR  [NV] = '{0,0,0,0,0,0,0,1,0,0,1,1,1,1,1,0};
   localparam logic [31:0] V_RD   [NV] = '{32'h1234_ABCD,0,32'hFFFF_FFFF,32'hFFFF_FFFF,0,32'h55,
                                           32'hFFFF_FFFF,0,32'h777,0,0,0,0,0,0,32'hA5A5};
   localparam int          V_TAG  [NV] = '{1,1,6,5,7,8,6,10,2,2,3,3,10,4,4,2};

   int lat;

   task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [1:0] sts, input logic [31:0] cd, input logic exp_req,
                         input logic [1:0] exp_kind, input logic exp_err, input logic [31:0] exp_rd,
                         input int tag, input int delay);
      int nreq = 0;
      int wcnt = 0;
      int req_at = -1;
      int cyc = 0;
      bit got = 0;
      logic [31:0] rd = '0;
      logic er = 0;
      @(negedge clk);
      h_valid = 1; h_write = wr; h_addr = addr; h_wdata = wd;
      while (!got && cyc < 400) begin
         @(negedge clk);
         cyc++;
         d_cpl_valid = 0;
         if (wcnt > 0) begin
            wcnt--;
            if (wcnt == 0) begin
               d_cpl_valid = 1; d_cpl_status = sts; d_cpl_data = cd;
            end
         end
         if (d_req_valid) begin
            nreq++;
            req_at = cyc;
            wcnt = delay;
            // R1 / R2 request contents
            check(d_req_kind == exp_kind, tag, d_req_kind, exp_kind);
            if (exp_kind < 2) begin
               check({d_req_bus, d_req_dev, d_req_fn, d_req_reg} == {addr[27:20], addr[19:15], addr[14:12], addr[11:2]},
                     1, {d_req_bus, d_req_dev, d_req_fn, d_req_reg}, {addr[27:20], addr[19:15], addr[14:12], addr[11:2]});
            end else begin
               check(d_req_addr == addr, 2, d_req_addr, addr);
            end
            if (wr) check(d_req_wdata == wd, tag, d_req_wdata, wd);
         end
         if (h_ready) begin
            got = 1; rd = h_rdata; er = h_err;
            h_valid = 0;
         end
      end
      d_cpl_valid = 0;
      lat = (req_at >= 0) ? cyc - req_at : -1;
      check(got, tag, got, 1);
      check(nreq == int'(exp_req), tag, nreq, exp_req);
      check(er == exp_err, tag, er, exp_err);
      check(rd == exp_rd, tag, rd, exp_rd);
   endtask

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      check(h_ready == 0 && d_req_valid == 0, 11, {h_ready, d_req_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      check(h_ready == 0 && d_req_valid == 0, 11, {h_ready, d_req_valid}, 0);

      for (int i = 0; i < NV; i++) begin
         access(V_WR[i], V_ADDR[i], V_WD[i], V_STS[i], V_CD[i], V_REQ[i],
                V_KIND[i], V_ERR[i], V_RD[i], V_TAG[i], 1);
      end

      // R9 slow completion: one request, ready exactly one cycle after completion
      access(0, 32'h3000_0000, 0, 0, 32'hBEEF_0009, 1, 0, 0, 32'hBEEF_0009, 9, 20);
      check(lat == 21, 9, lat, 21);
      // R10 memory write with error status
      access(1, 32'h4100_0000, 32'h3, 2, 0, 1, 3, 1, 0, 10, 3);
      check(lat == 4, 9, lat, 4);
      // R5 absent function in a gap of the presence map (dev3 fn1)
      access(0, 32'h3001_9000, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 5, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule